// File: doc/BRIEF.md
# Program/Run Memory Front End

This block is the memory side of a small accumulator computer: a 4-bit address register, a sixteen-byte store that holds both instructions and data, and the steering that lets the store be filled by hand before a program runs. A single mode line picks where the store takes its address and write data from. In program mode the address and data switches drive the store and a one-cycle write strobe stores the byte. In run mode the address register drives the store address. The address register is loaded from the shared bus.

A run-mode read takes two cycles. In the first cycle the control sequencer puts an address on the bus and pulses the address-register load. In the second cycle it raises the read enable, and the addressed byte appears on the bus output. The bus output is flagged valid only while the block owns the bus. When it does not, the output is held at zero with the flag low, which stands in for a high-impedance driver. The address register never drives the bus. Reset clears the address register and leaves the stored bytes alone.

Top module: `prog_ram_frontend`

## Requirements
- R1: A clock edge with `rst_n` low sets the address register to 0. After reset, a run-mode read without a new load returns the byte at address 0.
- R2: A clock edge with `mar_load` high loads `bus_addr` into the address register. With `mar_load` low the register keeps its value, whatever `bus_addr` carries.
- R3: With `run_mode` = 0 (program mode), a clock edge with `sw_wr` high stores `sw_data` at address `sw_addr`.
- R4: With `run_mode` = 1 (run mode), `sw_wr` has no effect and the store keeps its contents.
- R5: `bus_valid` is high exactly when `run_mode` = 1 and `ram_oe` = 1. While `bus_valid` is low, `bus_out` is 0.
- R6: While `bus_valid` is high, `bus_out` equals the byte at the address held in the address register. It changes in the same cycle as `ram_oe`, so a read finishes one cycle after its address load.
- R7: In program mode, a clock edge with `sw_wr` low stores nothing.
- R8: Reset does not change the stored bytes.
- R9: The address register loads on `mar_load` in either mode. An address loaded in program mode is used by the first run-mode read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| run_mode | input | 1 | 1 = run (address register path), 0 = program (switch path) |
| sw_addr | input | 4 | Address switches |
| sw_data | input | 8 | Data switches |
| sw_wr | input | 1 | One-cycle write strobe, used only in program mode |
| bus_addr | input | 4 | Address bits taken from the shared bus |
| mar_load | input | 1 | Load the address register from `bus_addr` |
| ram_oe | input | 1 | Read enable; puts the addressed byte on the bus |
| bus_out | output | 8 | Byte driven toward the bus; 0 when not valid |
| bus_valid | output | 1 | High while the block drives the bus |

## Verification
The address register and the store both change on a clock edge, so the bench drives every input at a falling edge. It checks a load or write only at a later falling edge, one cycle after it was issued. The read path is combinational from `ram_oe`, `run_mode` and the address register. Each read check therefore samples one time unit after the falling edge that raised `ram_oe`, which is one cycle after the address load. The checks for ignored strobes and reset preservation read the affected address back through this same two-cycle read before any further write.

// File: rtl/prog_ram_pkg.sv
// Shared widths and the mode encoding for the program/run memory front end.
package prog_ram_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;

    // Mode line encoding: low selects the switch path.
    typedef enum logic {
        MODE_PROG = 1'b0,
        MODE_RUN  = 1'b1
    } mode_e;
endpackage

// File: rtl/prog_ram_mar.sv
// Address register. It loads the address bits from the shared bus when asked
// and holds its value otherwise. Assumes a synchronous active-low reset that
// clears it to zero. Its output goes only to the store address steering.
module prog_ram_mar #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Register update: reset to 0, else load on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/prog_ram_mux.sv
// Mode steering. Selects the store address from the switches or the address
// register, and lets the write strobe through only in program mode.
// Assumes the strobe is already one cycle wide (no debouncing here).
module prog_ram_mux #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              run_mode,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] mar_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    import prog_ram_pkg::*;

    // Source selection and write qualification by mode.
    always_comb begin
        if (mode_e'(run_mode) == MODE_RUN) begin
            mem_addr = mar_q;
            mem_we   = 1'b0;
        end else begin
            mem_addr = sw_addr;
            mem_we   = sw_wr;
        end
        mem_wdata = sw_data;
    end
endmodule

// File: rtl/prog_ram_store.sv
// Storage array with one shared address. The write is synchronous and the
// read is asynchronous. It has no reset, so contents survive a block reset.
module prog_ram_store #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Byte write on a qualified strobe.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // Asynchronous read of the selected word.
    assign rdata = mem[addr];
endmodule

// File: rtl/prog_ram_drv.sv
// Bus output stage. Models a three-state driver as data plus a valid flag.
// The data is forced to zero whenever the block does not own the bus.
module prog_ram_drv #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              run_mode,
    input  logic              oe,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_valid
);
    // Drive only in run mode with the read enable raised.
    always_comb begin
        bus_valid = run_mode & oe;
        bus_out   = bus_valid ? rdata : '0;
    end
endmodule

// File: rtl/prog_ram_frontend.sv
// Program/run memory front end: address register, mode steering, storage and
// bus output stage. Assumes the caller keeps the write strobe to one cycle and
// gives a read its address load one cycle ahead of the read enable.
module prog_ram_frontend #(
    parameter int unsigned ADDR_W = prog_ram_pkg::ADDR_W,
    parameter int unsigned DATA_W = prog_ram_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_mode,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              mar_load,
    input  logic              ram_oe,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_valid
);
    logic [ADDR_W-1:0] mar_q;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;

    prog_ram_mar #(.ADDR_W(ADDR_W)) u_mar (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mar_load),
        .d    (bus_addr),
        .q    (mar_q)
    );

    prog_ram_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .run_mode (run_mode),
        .sw_addr  (sw_addr),
        .sw_data  (sw_data),
        .sw_wr    (sw_wr),
        .mar_q    (mar_q),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we)
    );

    prog_ram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    prog_ram_drv #(.DATA_W(DATA_W)) u_drv (
        .run_mode (run_mode),
        .oe       (ram_oe),
        .rdata    (mem_rdata),
        .bus_out  (bus_out),
        .bus_valid(bus_valid)
    );
endmodule

// File: rtl/prog_ram_checker.sv
// Property checker for the program/run memory front end. It is bound to the
// top module and watches its ports and the address register.
module prog_ram_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_mode,
    input logic              sw_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mar_load,
    input logic              ram_oe,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] mar_q
);
    // R1: a reset edge leaves the address register at zero.
    assert_mar_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (mar_q == '0));

    // R2: a load takes the bus address.
    assert_mar_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mar_load |=> (mar_q == $past(bus_addr)));

    // R2: without a load the address register holds.
    assert_mar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mar_load |=> $stable(mar_q));

    // R5: program mode never drives the bus.
    assert_prog_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode |-> !bus_valid);

    // R5: an undriven bus output reads as zero.
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_out == '0));

    // R6: the read enable in run mode claims the bus.
    assert_read_claims_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && ram_oe) |-> bus_valid);

    // R4: a steady run-mode read stays steady even with a switch strobe.
    assert_run_read_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && ram_oe && $past(run_mode) && $past(ram_oe)
         && !$past(mar_load) && $past(rst_n) && $past(sw_wr))
        |-> $stable(bus_out));
endmodule

bind prog_ram_frontend prog_ram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_mode (run_mode),
    .sw_wr    (sw_wr),
    .bus_addr (bus_addr),
    .mar_load (mar_load),
    .ram_oe   (ram_oe),
    .bus_out  (bus_out),
    .bus_valid(bus_valid),
    .mar_q    (mar_q)
);

// File: tb/sim_prog_ram_frontend.sv
module sim_prog_ram_frontend;
    localparam int PERIOD = 10;
    localparam int NVEC = 8;
    // Each entry: {address[11:8], data[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h0A5, 12'hF3C, 12'h100, 12'h2FF,
        12'h75A, 12'h881, 12'hC7E, 12'h512
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_mode = 1'b0;
    logic [3:0] sw_addr = '0;
    logic [7:0] sw_data = '0;
    logic       sw_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       mar_load = 1'b0;
    logic       ram_oe = 1'b0;
    logic [7:0] bus_out;
    logic       bus_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    prog_ram_frontend u0 (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
        .sw_addr(sw_addr), .sw_data(sw_data), .sw_wr(sw_wr),
        .bus_addr(bus_addr), .mar_load(mar_load), .ram_oe(ram_oe),
        .bus_out(bus_out), .bus_valid(bus_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        run_mode = 1'b0; sw_addr = a; sw_data = d; sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    // Two-cycle read: load the address, then enable and sample.
    task automatic run_read(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        run_mode = 1'b1; ram_oe = 1'b0; bus_addr = a; mar_load = 1'b1;
        @(negedge clk);
        mar_load = 1'b0; ram_oe = 1'b1; bus_addr = ~a;
        #1;
        chk({req, " valid"}, {7'b0, bus_valid}, 8'h01);
        chk(req, bus_out, exp);
        @(negedge clk);
        ram_oe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R5 reset idle valid", {7'b0, bus_valid}, 8'h00);
        chk("R5 reset idle data", bus_out, 8'h00);
        rst_n = 1'b1;

        // Table walk: program every entry, then read each back (R3, R6).
        for (int i = 0; i < NVEC; i++)
            prog_write(VEC[i][11:8], VEC[i][7:0]);
        for (int i = 0; i < NVEC; i++)
            run_read(VEC[i][11:8], VEC[i][7:0], "R3 R6 table read");

        // R4: a strobe in run mode does not write.
        @(negedge clk);
        run_mode = 1'b1; sw_addr = 4'h7; sw_data = 8'hEE; sw_wr = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
        run_read(4'h7, 8'h5A, "R4 run-mode strobe ignored");

        // R7: program mode without a strobe does not write.
        @(negedge clk);
        run_mode = 1'b0; sw_addr = 4'h8; sw_data = 8'h00; sw_wr = 1'b0;
        @(negedge clk);
        run_read(4'h8, 8'h81, "R7 no strobe no write");

        // R5: read enable in program mode leaves the bus undriven.
        @(negedge clk);
        run_mode = 1'b0; ram_oe = 1'b1;
        #1;
        chk("R5 prog-mode valid", {7'b0, bus_valid}, 8'h00);
        chk("R5 prog-mode data", bus_out, 8'h00);
        @(negedge clk);
        run_mode = 1'b1; ram_oe = 1'b0;
        #1;
        chk("R5 run no-oe valid", {7'b0, bus_valid}, 8'h00);
        chk("R5 run no-oe data", bus_out, 8'h00);

        // R2: the register holds while the bus address changes.
        run_read(4'h5, 8'h12, "R2 load");
        @(negedge clk);
        bus_addr = 4'hC; ram_oe = 1'b1;
        @(negedge clk);
        bus_addr = 4'h2;
        #1;
        chk("R2 hold", bus_out, 8'h12);
        @(negedge clk);
        ram_oe = 1'b0;

        // R9: load in program mode, read in run mode without a new load.
        @(negedge clk);
        run_mode = 1'b0; bus_addr = 4'hF; mar_load = 1'b1;
        @(negedge clk);
        mar_load = 1'b0; run_mode = 1'b1; ram_oe = 1'b1;
        #1;
        chk("R9 program-mode load", bus_out, 8'h3C);
        @(negedge clk);
        ram_oe = 1'b0;

        // R3: overwrite one byte and read it back.
        prog_write(4'h2, 8'h69);
        run_read(4'h2, 8'h69, "R3 overwrite");

        // R1/R8: reset clears the register but keeps the bytes.
        @(negedge clk);
        run_mode = 1'b1; bus_addr = 4'hC; mar_load = 1'b1;
        @(negedge clk);
        mar_load = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; ram_oe = 1'b1;
        #1;
        chk("R1 address cleared", bus_out, 8'hA5);
        @(negedge clk);
        ram_oe = 1'b0;
        run_read(4'hC, 8'h7E, "R8 contents kept");
        run_read(4'h2, 8'h69, "R8 contents kept");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule